// File: doc/BRIEF.md
# Peripheral Interrupt Handler Multiplexer

This block gathers sixteen peripheral event channels behind one secondary interrupt handler. Every channel owns an enable (mask) bit and a routing (select) bit. A pulse on a channel input latches a pending flag for that channel. Enabled pending channels whose routing bit is clear drive the standard interrupt request upward. Enabled pending channels whose routing bit is set drive the transfer-server service request instead.

When the main controller acknowledges either request, the block returns a 24-bit vector for the highest-numbered enabled pending channel in the group that was acknowledged. It then clears only that channel's pending flag. Standard vectors are spaced four bytes apart from a base address. Transfer-server vectors come from a separate table that starts at FF20C2h, with the same spacing. An acknowledge that finds nothing to serve in its group returns a fixed dummy code and clears nothing.

The transfer engine can report that a channel's transfer count reached zero. The block then drops that channel's routing bit and, one cycle later, signals the main controller to drop its own routing bit for this handler.

Top module: `perint_hub`

## Requirements
- R1: After a synchronous reset the mask, select and pending state are all zero, both request outputs are low, and reads return 0000h.
- R2: A write with wr_sel=0 loads the mask register, and a write with wr_sel=1 loads the select register. rd_data shows the select register when rd_sel=1 and the mask register when rd_sel=0, one cycle after rd_sel is applied.
- R3: A pulse on a masked channel still sets its pending flag. The request is raised once the channel is unmasked, and not before.
- R4: irq_std is high one cycle after some channel is pending, enabled and has its select bit at 0. irq_xfer is high under the same condition with the select bit at 1.
- R5: A standard acknowledge returns STD_BASE (FF2200h) + 4 x index of the highest-numbered enabled, pending, standard-routed channel on ack_vec in the next cycle, and clears only that channel's pending flag.
- R6: A transfer acknowledge returns FF20C2h + 4 x index of the highest-numbered enabled, pending, transfer-routed channel (FF20FEh for channel 15), and clears only that channel's pending flag.
- R7: An acknowledge with nothing to serve in its group returns the dummy code FFFFFEh and clears no pending flag. A pending transfer request therefore stays asserted after a standard dummy acknowledge.
- R8: A count-zero report (cz_valid with channel cz_chan) clears that channel's select bit, even against a select write in the same cycle, and sel_clr_up pulses high for one cycle on the next cycle.
- R9: A channel pulse that arrives in the same cycle as an acknowledge of that channel leaves the channel pending.
- R10: If ack_std and ack_xfer arrive together, only the standard acknowledge is served and no transfer-routed flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 mask, 1 select |
| wr_data | input | 16 | Write data, one bit per channel |
| rd_sel | input | 1 | Read source: 0 mask, 1 select |
| rd_data | output | 16 | Registered read data |
| chan_pulse | input | 16 | Per-channel event pulses |
| ack_std | input | 1 | Standard request acknowledge |
| ack_xfer | input | 1 | Transfer-server request acknowledge |
| cz_valid | input | 1 | Transfer count reached zero |
| cz_chan | input | 4 | Channel whose count reached zero |
| irq_std | output | 1 | Standard interrupt request |
| irq_xfer | output | 1 | Transfer-server service request |
| ack_vec | output | 24 | Vector returned for the last acknowledge |
| sel_clr_up | output | 1 | Pulse telling the main controller to drop its select bit for this handler |

## Verification
Single pending channels, both masked and unmasked, show whether pending capture is kept apart from enabling and whether each routing bit steers to the right request line. Pairs and triples of pending channels within a group show whether the priority order is highest-index-first, and whether each acknowledge clears exactly one flag. Mixed groups, where standard and transfer channels are pending together, are acknowledged one at a time and together. They show that the vector tables are kept separate, that a dummy answer leaves the other request standing, and that simultaneous acknowledges are arbitrated. Collisions of a count-zero report with a select write, and of a pulse with its own acknowledge, test which side wins each same-cycle race.

// File: rtl/perint_pkg.sv
package perint_pkg;
  localparam int VW     = 24;
  localparam int STRIDE = 4;
  localparam logic [VW-1:0] XFR_BASE  = 24'hFF20C2;
  localparam logic [VW-1:0] DUMMY_VEC = 24'hFFFFFE;

  function automatic logic [VW-1:0] chan_vec(input logic [VW-1:0] base, input int unsigned idx);
    return base + VW'(idx * STRIDE);
  endfunction
endpackage

// File: rtl/perint_regs.sv
module perint_regs #(
  parameter int NCH = 16,
  localparam int IW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic           wr_sel,
  input  logic [NCH-1:0] wr_data,
  input  logic           rd_sel,
  input  logic           cz_valid,
  input  logic [IW-1:0]  cz_chan,
  output logic [NCH-1:0] mask_q,
  output logic [NCH-1:0] sel_q,
  output logic [NCH-1:0] rd_data,
  output logic           sel_clr_up
);
  logic [NCH-1:0] sel_nx;

  always_comb begin
    sel_nx = (wr_en && wr_sel) ? wr_data : sel_q;
    if (cz_valid) sel_nx[cz_chan] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q     <= '0;
      sel_q      <= '0;
      rd_data    <= '0;
      sel_clr_up <= 1'b0;
    end else begin
      if (wr_en && !wr_sel) mask_q <= wr_data;
      sel_q      <= sel_nx;
      rd_data    <= rd_sel ? sel_q : mask_q;
      sel_clr_up <= cz_valid;
    end
  end

  // R8: count-zero wins over a same-cycle select write
  assert_cz_clears_sel_R8: assert property (@(posedge clk) disable iff (rst)
    cz_valid |=> (sel_q[$past(cz_chan)] == 1'b0));
  assert_cz_pulses_up_R8: assert property (@(posedge clk) disable iff (rst)
    cz_valid |=> sel_clr_up);
endmodule

// File: rtl/perint_pend.sv
module perint_pend #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] pulse,
  input  logic [NCH-1:0] clr,
  output logic [NCH-1:0] pend
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)           pend[i] <= 1'b0;
      else if (pulse[i]) pend[i] <= 1'b1;
      else if (clr[i])   pend[i] <= 1'b0;
    end

    // R3 / R9: a pulse always leaves the channel pending
    assert_pulse_sets_R9: assert property (@(posedge clk) disable iff (rst)
      pulse[i] |=> pend[i]);
  end

  // R5 / R6: at most one flag is cleared per acknowledge
  assert_single_clear_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr));
endmodule

// File: rtl/perint_prio.sv
module perint_prio #(
  parameter int NCH = 16,
  localparam int IW = $clog2(NCH)
) (
  input  logic [NCH-1:0] req,
  output logic           any,
  output logic [IW-1:0]  idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < NCH; i++) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/perint_hub.sv
module perint_hub
  import perint_pkg::*;
#(
  parameter int NCH = 16,
  parameter logic [23:0] STD_BASE = 24'hFF2200,
  localparam int IW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic           wr_sel,
  input  logic [NCH-1:0] wr_data,
  input  logic           rd_sel,
  output logic [NCH-1:0] rd_data,
  input  logic [NCH-1:0] chan_pulse,
  input  logic           ack_std,
  input  logic           ack_xfer,
  input  logic           cz_valid,
  input  logic [IW-1:0]  cz_chan,
  output logic           irq_std,
  output logic           irq_xfer,
  output logic [VW-1:0]  ack_vec,
  output logic           sel_clr_up
);
  logic [NCH-1:0] mask_q, sel_q, pend, clr;
  logic [NCH-1:0] grp_req [2];
  logic           grp_any [2];
  logic [IW-1:0]  grp_idx [2];

  perint_regs #(.NCH(NCH)) u_regs (
    .clk, .rst, .wr_en, .wr_sel, .wr_data, .rd_sel, .cz_valid, .cz_chan,
    .mask_q, .sel_q, .rd_data, .sel_clr_up
  );

  perint_pend #(.NCH(NCH)) u_pend (
    .clk, .rst, .pulse(chan_pulse), .clr, .pend
  );

  assign grp_req[0] = pend & mask_q & ~sel_q;
  assign grp_req[1] = pend & mask_q &  sel_q;

  for (genvar g = 0; g < 2; g++) begin : g_grp
    perint_prio #(.NCH(NCH)) u_prio (
      .req(grp_req[g]), .any(grp_any[g]), .idx(grp_idx[g])
    );
  end

  always_comb begin
    clr = '0;
    if (ack_std) begin
      if (grp_any[0]) clr[grp_idx[0]] = 1'b1;
    end else if (ack_xfer) begin
      if (grp_any[1]) clr[grp_idx[1]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_std  <= 1'b0;
      irq_xfer <= 1'b0;
      ack_vec  <= '0;
    end else begin
      irq_std  <= |grp_req[0];
      irq_xfer <= |grp_req[1];
      if (ack_std)
        ack_vec <= grp_any[0] ? chan_vec(STD_BASE, int'(grp_idx[0])) : DUMMY_VEC;
      else if (ack_xfer)
        ack_vec <= grp_any[1] ? chan_vec(XFR_BASE, int'(grp_idx[1])) : DUMMY_VEC;
    end
  end

  // R7: empty standard acknowledge gives the dummy code and clears nothing
  assert_dummy_code_R7: assert property (@(posedge clk) disable iff (rst)
    (ack_std && !grp_any[0]) |=> (ack_vec == DUMMY_VEC));
  assert_dummy_keeps_pend_R7: assert property (@(posedge clk) disable iff (rst)
    (ack_std && !grp_any[0] && chan_pulse == '0) |=> (pend == $past(pend)));
  // R10: a transfer acknowledge alongside a standard one clears no transfer flag
  assert_std_first_R10: assert property (@(posedge clk) disable iff (rst)
    (ack_std && ack_xfer) |=> ((pend & $past(grp_req[1])) == $past(grp_req[1])));
endmodule

// File: tb/tb_perint_hub.sv
`timescale 1ns/1ps
module tb_perint_hub;
  localparam logic [23:0] SB = 24'hFF2200;
  localparam logic [23:0] XB = 24'hFF20C2;
  localparam logic [23:0] DV = 24'hFFFFFE;

  logic clk = 0, rst = 1;
  logic wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [15:0] wr_data = '0, chan_pulse = '0, rd_data;
  logic ack_std = 0, ack_xfer = 0, cz_valid = 0;
  logic [3:0] cz_chan = '0;
  logic irq_std, irq_xfer, sel_clr_up;
  logic [23:0] ack_vec;
  int errors = 0, checks = 0, cycles = 0;

  always #2.5 clk = ~clk;

  perint_hub dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic do_reset();
    rst = 1; step(); step(); rst = 0; step();
  endtask

  task automatic wr(input logic s, input logic [15:0] d);
    wr_en = 1; wr_sel = s; wr_data = d; step(); wr_en = 0;
  endtask

  task automatic rd(input logic s, output logic [15:0] d);
    rd_sel = s; step(); d = rd_data;
  endtask

  task automatic pulse(input logic [15:0] p);
    chan_pulse = p; step(); chan_pulse = '0;
  endtask

  task automatic ack(input logic s, input logic x, output logic [23:0] v);
    ack_std = s; ack_xfer = x; step(); ack_std = 0; ack_xfer = 0; v = ack_vec;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    do_reset(); step();
    check("R1 irq_std", irq_std, 0);
    check("R1 irq_xfer", irq_xfer, 0);
    rd(0, d); check("R1 mask", d, 0);
    rd(1, d); check("R1 sel", d, 0);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    do_reset();
    wr(0, 16'hA5C3); wr(1, 16'h0F0F);
    rd(0, d); check("R2 mask read", d, 16'hA5C3);
    rd(1, d); check("R2 sel read", d, 16'h0F0F);
  endtask

  task automatic t_masked();
    logic [23:0] v;
    do_reset();
    pulse(16'h0008); step();
    check("R3 masked no irq", irq_std, 0);
    wr(0, 16'h0008); step();
    check("R3 unmask raises irq_std", irq_std, 1);
    check("R4 irq_xfer low for std", irq_xfer, 0);
    ack(1, 0, v); check("R5 vector ch3", v, SB + 12);
    step(); check("R5 irq drops", irq_std, 0);
  endtask

  task automatic t_prio();
    logic [23:0] v;
    do_reset();
    wr(0, 16'h0204);
    pulse(16'h0204); step();
    ack(1, 0, v); check("R5 highest ch9", v, SB + 36);
    step(); check("R5 ch2 still requests", irq_std, 1);
    ack(1, 0, v); check("R5 then ch2", v, SB + 8);
    ack(1, 0, v); check("R7 empty std dummy", v, DV);
  endtask

  task automatic t_xfer();
    logic [23:0] v;
    do_reset();
    wr(0, 16'h9020); wr(1, 16'h9020);
    pulse(16'h9020); step();
    check("R4 irq_xfer", irq_xfer, 1);
    check("R4 irq_std low", irq_std, 0);
    ack(1, 0, v); check("R7 std dummy", v, DV);
    step(); check("R7 xfer stays", irq_xfer, 1);
    ack(0, 1, v); check("R6 ch15", v, 24'hFF20FE);
    ack(0, 1, v); check("R6 ch12", v, 24'hFF20F2);
    ack(0, 1, v); check("R6 ch5", v, XB + 20);
    ack(0, 1, v); check("R7 xfer dummy", v, DV);
  endtask

  task automatic t_both();
    logic [23:0] v;
    do_reset();
    wr(0, 16'h8002); wr(1, 16'h8000);
    pulse(16'h8002); step();
    ack(1, 1, v); check("R10 std served", v, SB + 4);
    step(); check("R10 xfer kept", irq_xfer, 1);
    check("R10 std cleared", irq_std, 0);
    ack(0, 1, v); check("R10 xfer later", v, 24'hFF20FE);
  endtask

  task automatic t_cz();
    logic [15:0] d;
    do_reset();
    cz_valid = 1; cz_chan = 4'd12; wr_en = 1; wr_sel = 1; wr_data = 16'hFFFF;
    step(); cz_valid = 0; wr_en = 0;
    check("R8 sel_clr_up pulse", sel_clr_up, 1);
    step(); check("R8 sel_clr_up one cycle", sel_clr_up, 0);
    rd(1, d); check("R8 sel bit12 cleared", d, 16'hEFFF);
  endtask

  task automatic t_collide();
    logic [23:0] v;
    do_reset();
    wr(0, 16'h0008);
    pulse(16'h0008); step();
    chan_pulse = 16'h0008; ack(1, 0, v); chan_pulse = '0;
    check("R9 vector ch3", v, SB + 12);
    step(); check("R9 still pending", irq_std, 1);
    ack(1, 0, v); check("R9 served again", v, SB + 12);
  endtask

  initial begin
    t_reset(); t_regs(); t_masked(); t_prio();
    t_xfer(); t_both(); t_cz(); t_collide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=done", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule